// File: doc/BRIEF.md
# Three-Channel Bark/Bite Watchdog Timer

This peripheral holds three watchdog channels behind one 32-bit register port. Every channel owns an up-counter that advances by one on each cycle where the reference tick input is high, a bite threshold and a control word. When a channel's reset enable is on and its counter has reached or passed its bite threshold, it holds a reset request for as long as that condition is true. Channel 0 asks for a reset into recovery mode. Channels 1 and 2 share a normal-reset request output.

Channel 0 also has a bark threshold. With its interrupt enable on, reaching the bark threshold latches a sticky status bit that drives the interrupt line. Software clears that bit by writing 1 to it. Software keeps a channel alive by writing 0 to its counter. Any other value may be written as well, for example to shorten or lengthen the current interval.

Top module: `wdg_bank`

## Requirements
- R1: After reset every counter reads 0, every bite and bark threshold reads all ones, every control word reads 0, and all three outputs are low.
- R2: Each counter rises by exactly one on every clock cycle where `tick` is high and holds where `tick` is low. It wraps from all ones to 0.
- R3: A write to a counter loads the written value, and that write wins over a tick in the same cycle.
- R4: A channel requests reset whenever control bit 2 (reset enable) is 1 and its counter is unsigned greater than or equal to its bite threshold. This is a level test. Channel 0 drives `rst_recovery_req`. Channels 1 and 2 are OR-ed onto `rst_normal_req`.
- R5: A bite threshold of 0 with reset enable set raises the request in the cycle after the write, whatever the counter holds.
- R6: On channel 0, when control bit 0 (interrupt enable) is 1 and the counter is greater than or equal to the bark threshold, control bit 1 (status) is set on the next clock edge. `irq` equals that status bit.
- R7: The status bit is sticky. Writing 1 to control bit 1 clears it unless the bark condition still holds. Writing 0 to that bit leaves it unchanged.
- R8: On channels 1 and 2, control bits 0 and 1 always read 0 and never raise `irq`. Only bit 2 is writable.
- R9: The following offsets read 0 and ignore writes: byte offsets 0x18 and 0x28, which are the bark slots of channels 1 and 2; offsets beyond channel 2 (0x30 and up); and any offset whose two low bits are not 0.
- R10: Channel n sits at byte base 0x10*n. Within it, the counter is at +0x0, bite at +0x4, bark at +0x8 (channel 0 only) and control at +0xC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Reference tick enable; counters advance when high |
| wen | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| rst_recovery_req | output | 1 | Recovery reset request from channel 0 |
| rst_normal_req | output | 1 | Normal reset request from channels 1 and 2 |
| irq | output | 1 | Bark interrupt from channel 0 |

## Verification
The bite comparison is driven with a table of counter and threshold pairs on all three channels: below, equal, above, zero threshold, the all-ones extreme, and one pair that straddles the sign bit. These separate a correct unsigned greater-or-equal test from strict, signed or edge-triggered versions, and they show the reset-enable gating. Ticked runs separate a counter that advances from one that holds, wraps or loses to a write. The bark sequence writes clears while the condition is true and after it has gone away, so a sticky, correctly prioritised status bit can be told from a plain copy of the compare. Register-map probes catch aliasing of the missing bark slots and of out-of-range offsets.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   // Register slot inside one channel's 16-byte window (address bits [3:2])
   typedef enum logic [1:0] {
      SLOT_CNT  = 2'd0,
      SLOT_BITE = 2'd1,
      SLOT_BARK = 2'd2,
      SLOT_CTRL = 2'd3
   } wdg_slot_e;

   // Control word bit positions
   localparam int CTRL_IRQ_EN = 0;
   localparam int CTRL_IRQ_ST = 1;
   localparam int CTRL_RST_EN = 2;

   // log2 of the byte stride between channel windows
   localparam int CH_STRIDE_LG2 = 4;

   typedef struct packed {
      logic cnt;
      logic bite;
      logic bark;
      logic ctrl;
   } wdg_we_t;

endpackage

// File: rtl/wdg_decode.sv
module wdg_decode
   import wdg_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int NUM_CH  = 3,
   parameter int BARK_CH = 0
) (
   input  logic              wen_i,
   input  logic [ADDR_W-1:0] addr_i,
   output wdg_we_t           we_o  [NUM_CH],
   output logic [NUM_CH-1:0] rd_sel_o,
   output wdg_slot_e         slot_o
);

   localparam int CH_W = ADDR_W - CH_STRIDE_LG2;

   logic [CH_W-1:0] ch_idx;
   logic            aligned;
   logic            in_range;
   logic            hit;
   wdg_slot_e       slot;

   assign ch_idx   = addr_i[ADDR_W-1:CH_STRIDE_LG2];
   assign slot     = wdg_slot_e'(addr_i[3:2]);
   assign aligned  = (addr_i[1:0] == 2'b00);
   assign in_range = (int'(ch_idx) < NUM_CH);
   assign hit      = aligned && in_range &&
                     ((slot != SLOT_BARK) || (int'(ch_idx) == BARK_CH));
   assign slot_o   = slot;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
      logic mine;
      assign mine          = hit && (int'(ch_idx) == g);
      assign rd_sel_o[g]   = mine;
      assign we_o[g].cnt   = wen_i && mine && (slot == SLOT_CNT);
      assign we_o[g].bite  = wen_i && mine && (slot == SLOT_BITE);
      assign we_o[g].bark  = wen_i && mine && (slot == SLOT_BARK);
      assign we_o[g].ctrl  = wen_i && mine && (slot == SLOT_CTRL);
   end

endmodule

// File: rtl/wdg_channel.sv
module wdg_channel
   import wdg_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit HAS_BARK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  wdg_we_t           we_i,
   input  wdg_slot_e         slot_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [DATA_W-1:0] cnt_o,
   output logic [DATA_W-1:0] bite_o,
   output logic [DATA_W-1:0] bark_o,
   output logic              rst_en_o,
   output logic              irq_en_o,
   output logic              rst_req_o,
   output logic              irq_o
);

   localparam logic [DATA_W-1:0] ONES = '1;
   localparam int                PAD  = DATA_W - 3;

   logic [DATA_W-1:0] cnt_q;
   logic [DATA_W-1:0] bite_q;
   logic              rst_en_q;
   logic [DATA_W-1:0] ctrl_word;

   // Counter: software write wins over the tick of the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (we_i.cnt) begin
         cnt_q <= wdata_i;
      end else if (tick_i) begin
         cnt_q <= cnt_q + DATA_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bite_q   <= ONES;
         rst_en_q <= 1'b0;
      end else begin
         if (we_i.bite) bite_q   <= wdata_i;
         if (we_i.ctrl) rst_en_q <= wdata_i[CTRL_RST_EN];
      end
   end

   assign rst_req_o = rst_en_q && (cnt_q >= bite_q);
   assign cnt_o     = cnt_q;
   assign bite_o    = bite_q;
   assign rst_en_o  = rst_en_q;

   if (HAS_BARK) begin : g_bark
      logic [DATA_W-1:0] bark_q;
      logic              irq_en_q;
      logic              stat_q;
      logic              bark_hit;
      logic              clr_req;

      assign bark_hit = irq_en_q && (cnt_q >= bark_q);
      assign clr_req  = we_i.ctrl && wdata_i[CTRL_IRQ_ST];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bark_q   <= ONES;
            irq_en_q <= 1'b0;
            stat_q   <= 1'b0;
         end else begin
            if (we_i.bark) bark_q   <= wdata_i;
            if (we_i.ctrl) irq_en_q <= wdata_i[CTRL_IRQ_EN];
            // sticky: set by a live bark condition, cleared by write-one
            stat_q <= (stat_q && !clr_req) || bark_hit;
         end
      end

      assign bark_o    = bark_q;
      assign irq_en_o  = irq_en_q;
      assign irq_o     = stat_q;
      assign ctrl_word = {{PAD{1'b0}}, rst_en_q, stat_q, irq_en_q};
   end else begin : g_plain
      logic unused_bark;
      assign unused_bark = we_i.bark ^ wdata_i[CTRL_IRQ_EN] ^ wdata_i[CTRL_IRQ_ST];
      assign bark_o    = ONES;
      assign irq_en_o  = 1'b0;
      assign irq_o     = 1'b0;
      assign ctrl_word = {{PAD{1'b0}}, rst_en_q, 2'b00};
   end

   always_comb begin
      unique case (slot_i)
         SLOT_CNT:  rdata_o = cnt_q;
         SLOT_BITE: rdata_o = bite_q;
         SLOT_BARK: rdata_o = HAS_BARK ? bark_o : '0;
         SLOT_CTRL: rdata_o = ctrl_word;
         default:   rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/wdg_bank.sv
module wdg_bank
   import wdg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6,
   parameter int NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wen,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rst_recovery_req,
   output logic              rst_normal_req,
   output logic              irq
);

   localparam int BARK_CH  = 0;
   localparam int MAX_CH   = 1 << (ADDR_W - CH_STRIDE_LG2);

   if (DATA_W < 3) begin : g_bad_data
      $error("wdg_bank: DATA_W must hold the three control bits");
   end
   if (ADDR_W <= CH_STRIDE_LG2) begin : g_bad_addr
      $error("wdg_bank: ADDR_W too small for one channel window");
   end
   if (NUM_CH < 2 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("wdg_bank: NUM_CH must be at least 2 and fit the address space");
   end

   wdg_we_t           ch_we   [NUM_CH];
   logic [NUM_CH-1:0] rd_sel;
   wdg_slot_e         rd_slot;
   logic [DATA_W-1:0] ch_rdata [NUM_CH];
   logic [DATA_W-1:0] cnt_all  [NUM_CH];
   logic [DATA_W-1:0] bite_all [NUM_CH];
   logic [DATA_W-1:0] bark_all [NUM_CH];
   logic [NUM_CH-1:0] rst_en_all;
   logic [NUM_CH-1:0] irq_en_all;
   logic [NUM_CH-1:0] rst_req;
   logic [NUM_CH-1:0] irq_all;

   wdg_decode #(
      .ADDR_W  (ADDR_W),
      .NUM_CH  (NUM_CH),
      .BARK_CH (BARK_CH)
   ) u_decode (
      .wen_i    (wen),
      .addr_i   (addr),
      .we_o     (ch_we),
      .rd_sel_o (rd_sel),
      .slot_o   (rd_slot)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      wdg_channel #(
         .DATA_W   (DATA_W),
         .HAS_BARK (g == BARK_CH)
      ) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick_i    (tick),
         .wdata_i   (wdata),
         .we_i      (ch_we[g]),
         .slot_i    (rd_slot),
         .rdata_o   (ch_rdata[g]),
         .cnt_o     (cnt_all[g]),
         .bite_o    (bite_all[g]),
         .bark_o    (bark_all[g]),
         .rst_en_o  (rst_en_all[g]),
         .irq_en_o  (irq_en_all[g]),
         .rst_req_o (rst_req[g]),
         .irq_o     (irq_all[g])
      );
   end

   // Read mux: OR of the selected channel (select is one-hot or zero)
   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rd_sel[i]) rdata = rdata | ch_rdata[i];
      end
   end

   assign rst_recovery_req = rst_req[BARK_CH];
   assign rst_normal_req   = |rst_req[NUM_CH-1:1];
   assign irq              = irq_all[BARK_CH];

   logic unused_obs;
   assign unused_obs = ^{irq_en_all[NUM_CH-1:1], irq_all[NUM_CH-1:1]};

endmodule

// File: rtl/wdg_bank_chk.sv
module wdg_bank_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wen,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              rst_recovery_req,
   input logic              irq,
   input logic [DATA_W-1:0] cnt0,
   input logic [DATA_W-1:0] bark0,
   input logic              rst_en0,
   input logic              irq_en0
);

   localparam logic [ADDR_W-1:0] A_CNT0  = ADDR_W'(8'h00);
   localparam logic [ADDR_W-1:0] A_CTRL0 = ADDR_W'(8'h0C);
   localparam logic [ADDR_W-1:0] A_HOLE1 = ADDR_W'(8'h18);

   logic wr_cnt0;
   logic clr0;
   assign wr_cnt0 = wen && (addr == A_CNT0);
   assign clr0    = wen && (addr == A_CTRL0) && wdata[1];

   AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_cnt0) |=> (cnt0 == $past(cnt0) + DATA_W'(1))); // R2

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_cnt0) |=> $stable(cnt0)); // R2

   AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt0 |=> (cnt0 == $past(wdata))); // R3

   AST_RECOVERY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      rst_recovery_req |-> rst_en0); // R4

   AST_BARK_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en0 && (cnt0 >= bark0)) |=> irq); // R6

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr0) |=> irq); // R7

   AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr0 && !(irq_en0 && (cnt0 >= bark0))) |=> !irq); // R7

   AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_HOLE1) |-> (rdata == '0)); // R9

endmodule

bind wdg_bank wdg_bank_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .tick             (tick),
   .wen              (wen),
   .addr             (addr),
   .wdata            (wdata),
   .rdata            (rdata),
   .rst_recovery_req (rst_recovery_req),
   .irq              (irq),
   .cnt0             (cnt_all[0]),
   .bark0            (bark_all[0]),
   .rst_en0          (rst_en_all[0]),
   .irq_en0          (irq_en_all[0])
);

// File: tb/tb_wdg_bank.sv
module tb_wdg_bank;

   localparam int DW = 32;
   localparam int AW = 6;
   localparam logic [DW-1:0] ONES = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          wen = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rst_recovery_req;
   logic          rst_normal_req;
   logic          irq;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   wdg_bank #(.DATA_W(DW), .ADDR_W(AW), .NUM_CH(3)) dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .tick             (tick),
      .wen              (wen),
      .addr             (addr),
      .wdata            (wdata),
      .rdata            (rdata),
      .rst_recovery_req (rst_recovery_req),
      .rst_normal_req   (rst_normal_req),
      .irq              (irq)
   );

   typedef struct packed {
      logic [1:0]    ch;
      logic [DW-1:0] cnt;
      logic [DW-1:0] bite;
      logic          en;
      logic          exp_req;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 32'd5,          32'd10,         1'b1, 1'b0},
      '{2'd0, 32'd10,         32'd10,         1'b1, 1'b1},
      '{2'd0, 32'd11,         32'd10,         1'b1, 1'b1},
      '{2'd1, 32'd0,          32'd0,          1'b1, 1'b1},
      '{2'd1, 32'd9,          32'd3,          1'b0, 1'b0},
      '{2'd2, 32'hFFFF_FFFE,  32'hFFFF_FFFF,  1'b1, 1'b0},
      '{2'd2, 32'hFFFF_FFFF,  32'hFFFF_FFFF,  1'b1, 1'b1},
      '{2'd1, 32'h8000_0000,  32'h7FFF_FFFF,  1'b1, 1'b1}
   };

   // Called at a negedge; returns at the next negedge (one posedge applied)
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      addr = a; wdata = d; wen = 1'b1;
      @(negedge clk);
      wen = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      addr = a;
      #1;
      chk(req, rdata, exp);
   endtask

   task automatic run_all;
      // R1: reset state
      rd_chk("R1 cnt0",  6'h00, '0);
      rd_chk("R1 bite0", 6'h04, ONES);
      rd_chk("R1 bark0", 6'h08, ONES);
      rd_chk("R1 ctrl0", 6'h0C, '0);
      rd_chk("R1 cnt1",  6'h10, '0);
      rd_chk("R1 bite2", 6'h24, ONES);
      rd_chk("R1 ctrl2", 6'h2C, '0);
      chk("R1 outs", {29'd0, rst_recovery_req, rst_normal_req, irq}, '0);

      // R4 / R5 / R10: bite comparison table
      for (int i = 0; i < NV; i++) begin
         logic [AW-1:0] base;
         base = AW'(VEC[i].ch) << 4;
         wr(base + 6'h4, VEC[i].bite);
         wr(base,        VEC[i].cnt);
         wr(base + 6'hC, {29'd0, VEC[i].en, 2'b00});
         if (VEC[i].ch == 2'd0) begin
            chk($sformatf("R4 vec%0d recovery", i), {31'd0, rst_recovery_req}, {31'd0, VEC[i].exp_req});
            chk($sformatf("R4 vec%0d normal", i),   {31'd0, rst_normal_req},   '0);
         end else begin
            chk($sformatf("R4 R5 vec%0d normal", i), {31'd0, rst_normal_req},   {31'd0, VEC[i].exp_req});
            chk($sformatf("R4 vec%0d recovery", i),  {31'd0, rst_recovery_req}, '0);
         end
         wr(base + 6'hC, '0);
         wr(base + 6'h4, ONES);
         wr(base,        '0);
      end

      // R2: counting, holding, wrap
      wr(6'h00, 32'd7);
      tick = 1'b1; idle(5); tick = 1'b0;
      rd_chk("R2 advance", 6'h00, 32'd12);
      idle(3);
      rd_chk("R2 hold", 6'h00, 32'd12);
      wr(6'h20, ONES);
      tick = 1'b1; idle(1); tick = 1'b0;
      rd_chk("R2 wrap", 6'h20, '0);

      // R3: write wins over tick
      tick = 1'b1; wr(6'h10, 32'd100); tick = 1'b0;
      rd_chk("R3 write wins", 6'h10, 32'd100);

      // R4: level crossing by ticking on channel 2
      wr(6'h24, 32'd20);
      wr(6'h20, 32'd15);
      wr(6'h2C, 32'h4);
      tick = 1'b1; idle(4); tick = 1'b0;
      chk("R4 below bite", {31'd0, rst_normal_req}, '0);
      tick = 1'b1; idle(1); tick = 1'b0;
      chk("R4 reaches bite", {31'd0, rst_normal_req}, 32'd1);
      idle(2);
      chk("R4 level held", {31'd0, rst_normal_req}, 32'd1);
      wr(6'h2C, '0);
      chk("R4 disable drops", {31'd0, rst_normal_req}, '0);
      wr(6'h24, ONES);

      // R6 / R10: bark on channel 0
      wr(6'h08, 32'd50);
      rd_chk("R10 bark readback", 6'h08, 32'd50);
      wr(6'h00, 32'd100);
      wr(6'h0C, 32'h1);
      chk("R6 one-cycle latency", {31'd0, irq}, '0);
      idle(1);
      chk("R6 irq set", {31'd0, irq}, 32'd1);
      rd_chk("R6 ctrl status", 6'h0C, 32'h3);
      chk("R6 no recovery", {31'd0, rst_recovery_req}, '0);

      // R7: clear rules
      wr(6'h0C, 32'h3);
      idle(1);
      chk("R7 re-set while live", {31'd0, irq}, 32'd1);
      wr(6'h00, '0);
      idle(1);
      chk("R7 sticky", {31'd0, irq}, 32'd1);
      wr(6'h0C, 32'h1);
      chk("R7 write zero keeps", {31'd0, irq}, 32'd1);
      wr(6'h0C, 32'h3);
      chk("R7 write one clears", {31'd0, irq}, '0);
      wr(6'h0C, '0);

      // R8: channels 1/2 have no interrupt
      wr(6'h10, ONES);
      wr(6'h1C, 32'h3);
      rd_chk("R8 ctrl1 low bits", 6'h1C, '0);
      idle(2);
      chk("R8 no irq", {31'd0, irq}, '0);
      wr(6'h1C, 32'h7);
      rd_chk("R8 ctrl1 only bit2", 6'h1C, 32'h4);
      wr(6'h1C, '0);
      wr(6'h10, '0);

      // R9: unmapped offsets
      wr(6'h18, 32'd123);
      rd_chk("R9 hole 0x18", 6'h18, '0);
      rd_chk("R9 bite1 untouched", 6'h14, ONES);
      wr(6'h28, 32'd456);
      rd_chk("R9 hole 0x28", 6'h28, '0);
      rd_chk("R9 ctrl2 untouched", 6'h2C, '0);
      wr(6'h30, 32'd7);
      rd_chk("R9 beyond ch2", 6'h30, '0);
      rd_chk("R9 beyond no alias", 6'h00, '0);
      wr(6'h01, 32'd9);
      rd_chk("R9 misaligned", 6'h01, '0);
      rd_chk("R9 cnt0 untouched", 6'h00, '0);
      chk("R9 outs quiet", {29'd0, rst_recovery_req, rst_normal_req, irq}, '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      fork
         run_all();
         begin
            repeat (20000) @(negedge clk);
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule